// File: doc/BRIEF.md
# Two-Way Command Mailbox

This block lets two processors, called side A and side B, hand each other one command word and one data word at a time through a small register window. Each side reaches the window over its own simple 32-bit register bus: an address, a write strobe, write data and combinational read data. Each side also has its own interrupt line. There are two one-message channels. The forward channel carries messages from A to B, and the return channel carries messages from B to A.

The sender writes the command word, and in one mode also the data word. That write marks the channel pending. If the channel's enable bit is set, the pending flag raises the receiver's interrupt one cycle later. The receiver reads the command, then the data, and then writes 1 to the status bit to release the channel. The sender polls the same status bit: 1 means the channel is busy and 0 means the message was taken.

Each channel is a small state machine with three states:
- `ST_IDLE` means nothing is pending.
- `ST_CMD_HELD` means that in data-trigger mode a command has been written and the data write is still to come.
- `ST_PENDING` means a message waits for the receiver.

The transitions are:
- FIRE goes from any state to `ST_PENDING`.
- TAKE goes from `ST_PENDING` to `ST_IDLE` on a receiver clear.
- ARM goes from `ST_IDLE` to `ST_CMD_HELD` on a command write in data-trigger mode.
- HOLD keeps every other case in its current state.

Top module: `duplex_mailbox`

Register map, by byte offset. Both sides see the same map:

| Offset | Register |
|---|---|
| 0x00 | forward enable |
| 0x04 | forward status |
| 0x08 | forward command |
| 0x0C | forward data |
| 0x10 | return enable |
| 0x14 | return status |
| 0x18 | return command |
| 0x1C | return data |

## Requirements
- R1: After reset, every register reads 0 from both sides and both interrupt lines are 0.
- R2: An enable register takes a masked write: bit k (k < 16) changes only when bit k+16 of the same write is 1. Bit 0 is the interrupt enable. Bit 8 of the forward enable register is the trigger select. All other bits read 0.
- R3: With forward trigger select 0, a side-A write to 0x08 stores the command and sets forward status bit 0 (offset 0x04) on the next clock edge.
- R4: With forward trigger select 1, a write to 0x08 stores the command but leaves status at 0. The following side-A write to 0x0C sets status bit 0.
- R5: The return channel always fires on a side-B write to 0x18. Its bit 8 is not implemented and reads 0. A write to 0x1C alone does not fire it.
- R6: The receiver clears a pending flag by writing a 1 in bit 0 of the status offset. Writing 0 has no effect. A write to the status offset by the sender has no effect.
- R7: When a receiver clear and a firing write land on the same clock edge, the channel stays pending.
- R8: Each interrupt line is a registered AND of the channel's enable bit and its pending flag. b_irq serves the forward channel and a_irq serves the return channel. Each follows one cycle after the flag changes, and stays 0 while the enable bit is 0.
- R9: Command and data registers can be written only by the channel's sender. Writes from the receiver are ignored. Both registers keep their value until the sender overwrites them.
- R10: Offsets at 0x20 and above are reserved. Writes to them change nothing and reads of them return 0.
- R11: If both sides write the same enable register on the same edge, the side-A write takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| a_addr | input | 6 | Side A byte address |
| a_we | input | 1 | Side A write strobe |
| a_wdata | input | 32 | Side A write data |
| a_rdata | output | 32 | Side A read data |
| a_irq | output | 1 | Side A interrupt (return channel message) |
| b_addr | input | 6 | Side B byte address |
| b_we | input | 1 | Side B write strobe |
| b_wdata | input | 32 | Side B write data |
| b_rdata | output | 32 | Side B read data |
| b_irq | output | 1 | Side B interrupt (forward channel message) |

## Verification
The forward channel is run in both trigger modes. Command-only firing shows whether the select bit is honoured. The command-then-data sequence shows that the command write alone leaves the channel quiet. The return channel is fired with its unimplemented select bit written to 1, which would expose a wrongly shared trigger path. The masked enable writes are tried with and without their mask bits. Clears are tried from the sender, with a 0, and from the receiver. Same-edge collisions, a clear against a new message and two enable writes, check the priority rules. Receiver-side writes to command registers and writes to reserved offsets check that foreign writes leave the stored words untouched.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

    localparam int WORD_W   = 32;
    localparam int NUM_REGS = 8;
    localparam int IDX_W    = $clog2(NUM_REGS);

    // register slots, byte offset = slot * 4
    localparam int SLOT_FWD_EN   = 0;
    localparam int SLOT_FWD_STAT = 1;
    localparam int SLOT_FWD_CMD  = 2;
    localparam int SLOT_FWD_DAT  = 3;
    localparam int SLOT_RET_EN   = 4;
    localparam int SLOT_RET_STAT = 5;
    localparam int SLOT_RET_CMD  = 6;
    localparam int SLOT_RET_DAT  = 7;

    localparam int BIT_IRQ_EN   = 0;
    localparam int BIT_TRIG_SEL = 8;
    localparam int MASK_SHIFT   = 16;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_CMD_HELD = 2'd1,
        ST_PENDING  = 2'd2
    } chan_state_t;

endpackage

// File: rtl/mbox_side_port.sv
module mbox_side_port
    import mbox_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic [ADDR_W-1:0]                 addr,
    input  logic                              we,
    input  logic [NUM_REGS-1:0][WORD_W-1:0]   reg_words,
    output logic [NUM_REGS-1:0]               wr_slot,
    output logic [WORD_W-1:0]                 rdata
);

    localparam int WINDOW_BYTES = NUM_REGS * 4;

    logic             in_window;
    logic [IDX_W-1:0] slot;
    logic [1:0]       unused_byte_lane;

    assign in_window        = ({{(32-ADDR_W){1'b0}}, addr} < WINDOW_BYTES);
    assign slot             = addr[IDX_W+1:2];
    assign unused_byte_lane = addr[1:0];

    generate
        for (genvar i = 0; i < NUM_REGS; i++) begin : g_strobe
            assign wr_slot[i] = we && in_window && (slot == IDX_W'(i));
        end
    endgenerate

    always_comb begin
        if (in_window) rdata = reg_words[slot];
        else           rdata = '0;
    end

    always_comb begin
        if (!in_window) begin
            AST_RESERVED_READ: assert (rdata == '0); // R10
        end
    end

endmodule

// File: rtl/mbox_channel.sv
module mbox_channel
    import mbox_pkg::*;
#(
    parameter bit HAS_TRIG_SEL = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic              data_wr,
    input  logic [WORD_W-1:0] msg_wdata,
    input  logic              clr,
    input  logic              en_wr,
    input  logic              en_set,
    input  logic              en_msk,
    input  logic              trg_set,
    input  logic              trg_msk,
    output logic [WORD_W-1:0] cmd_q,
    output logic [WORD_W-1:0] data_q,
    output logic              pending,
    output logic              irq_en,
    output logic [WORD_W-1:0] en_word,
    output logic [WORD_W-1:0] stat_word
);

    chan_state_t state_q, state_d;
    logic        trig_q;
    logic        fire;

    // enable bit, masked write
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                irq_en <= 1'b0;
        else if (en_wr && en_msk)  irq_en <= en_set;
    end

    generate
        if (HAS_TRIG_SEL) begin : g_trig
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                trig_q <= 1'b0;
                else if (en_wr && trg_msk) trig_q <= trg_set;
            end
        end else begin : g_no_trig
            logic unused_trg;
            assign unused_trg = trg_set ^ trg_msk;
            assign trig_q     = 1'b0;
        end
    endgenerate

    assign fire = trig_q ? data_wr : cmd_wr;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state: FIRE beats TAKE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (fire)                  state_d = ST_PENDING;
                else if (cmd_wr && trig_q) state_d = ST_CMD_HELD;
            end
            ST_CMD_HELD: begin
                if (fire)                  state_d = ST_PENDING;
            end
            ST_PENDING: begin
                if (fire)                  state_d = ST_PENDING;
                else if (clr)              state_d = ST_IDLE;
            end
            default:                       state_d = ST_IDLE;
        endcase
    end

    // message words
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q  <= '0;
            data_q <= '0;
        end else begin
            if (cmd_wr)  cmd_q  <= msg_wdata;
            if (data_wr) data_q <= msg_wdata;
        end
    end

    // outputs
    always_comb begin
        pending   = (state_q == ST_PENDING);
        stat_word = '0;
        stat_word[0] = pending;
        en_word   = '0;
        en_word[BIT_IRQ_EN]   = irq_en;
        en_word[BIT_TRIG_SEL] = trig_q;
    end

    AST_FIRE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && clr) |=> pending); // R7
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !fire && pending) |=> !pending); // R6
    AST_CMD_HELD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_wr |=> $stable(cmd_q)); // R9
    AST_DATA_HELD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        !data_wr |=> $stable(data_q)); // R9
    AST_ENABLE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        !(en_wr && en_msk) |=> $stable(irq_en)); // R2

endmodule

// File: rtl/duplex_mailbox.sv
module duplex_mailbox
    import mbox_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic              a_we,
    input  logic [31:0]       a_wdata,
    output logic [31:0]       a_rdata,
    output logic              a_irq,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic              b_we,
    input  logic [31:0]       b_wdata,
    output logic [31:0]       b_rdata,
    output logic              b_irq
);

    logic [NUM_REGS-1:0]             a_wr, b_wr;
    logic [NUM_REGS-1:0][WORD_W-1:0] words;

    logic [WORD_W-1:0] fwd_cmd, fwd_dat, fwd_en_w, fwd_st_w;
    logic [WORD_W-1:0] ret_cmd, ret_dat, ret_en_w, ret_st_w;
    logic              fwd_pend, fwd_en, ret_pend, ret_en;
    logic              fwd_en_wr, ret_en_wr;
    logic [WORD_W-1:0] fwd_en_data, ret_en_data;

    mbox_side_port #(.ADDR_W(ADDR_W)) u_port_a (
        .addr(a_addr), .we(a_we), .reg_words(words),
        .wr_slot(a_wr), .rdata(a_rdata)
    );

    mbox_side_port #(.ADDR_W(ADDR_W)) u_port_b (
        .addr(b_addr), .we(b_we), .reg_words(words),
        .wr_slot(b_wr), .rdata(b_rdata)
    );

    // side A has priority on shared enable registers
    assign fwd_en_wr   = a_wr[SLOT_FWD_EN] || b_wr[SLOT_FWD_EN];
    assign fwd_en_data = a_wr[SLOT_FWD_EN] ? a_wdata : b_wdata;
    assign ret_en_wr   = a_wr[SLOT_RET_EN] || b_wr[SLOT_RET_EN];
    assign ret_en_data = a_wr[SLOT_RET_EN] ? a_wdata : b_wdata;

    mbox_channel #(.HAS_TRIG_SEL(1'b1)) u_fwd (
        .clk(clk), .rst_n(rst_n),
        .cmd_wr(a_wr[SLOT_FWD_CMD]), .data_wr(a_wr[SLOT_FWD_DAT]),
        .msg_wdata(a_wdata),
        .clr(b_wr[SLOT_FWD_STAT] && b_wdata[0]),
        .en_wr(fwd_en_wr),
        .en_set(fwd_en_data[BIT_IRQ_EN]),
        .en_msk(fwd_en_data[BIT_IRQ_EN + MASK_SHIFT]),
        .trg_set(fwd_en_data[BIT_TRIG_SEL]),
        .trg_msk(fwd_en_data[BIT_TRIG_SEL + MASK_SHIFT]),
        .cmd_q(fwd_cmd), .data_q(fwd_dat), .pending(fwd_pend),
        .irq_en(fwd_en), .en_word(fwd_en_w), .stat_word(fwd_st_w)
    );

    mbox_channel #(.HAS_TRIG_SEL(1'b0)) u_ret (
        .clk(clk), .rst_n(rst_n),
        .cmd_wr(b_wr[SLOT_RET_CMD]), .data_wr(b_wr[SLOT_RET_DAT]),
        .msg_wdata(b_wdata),
        .clr(a_wr[SLOT_RET_STAT] && a_wdata[0]),
        .en_wr(ret_en_wr),
        .en_set(ret_en_data[BIT_IRQ_EN]),
        .en_msk(ret_en_data[BIT_IRQ_EN + MASK_SHIFT]),
        .trg_set(ret_en_data[BIT_TRIG_SEL]),
        .trg_msk(ret_en_data[BIT_TRIG_SEL + MASK_SHIFT]),
        .cmd_q(ret_cmd), .data_q(ret_dat), .pending(ret_pend),
        .irq_en(ret_en), .en_word(ret_en_w), .stat_word(ret_st_w)
    );

    always_comb begin
        words                = '0;
        words[SLOT_FWD_EN]   = fwd_en_w;
        words[SLOT_FWD_STAT] = fwd_st_w;
        words[SLOT_FWD_CMD]  = fwd_cmd;
        words[SLOT_FWD_DAT]  = fwd_dat;
        words[SLOT_RET_EN]   = ret_en_w;
        words[SLOT_RET_STAT] = ret_st_w;
        words[SLOT_RET_CMD]  = ret_cmd;
        words[SLOT_RET_DAT]  = ret_dat;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_irq <= 1'b0;
            b_irq <= 1'b0;
        end else begin
            a_irq <= ret_en && ret_pend;
            b_irq <= fwd_en && fwd_pend;
        end
    end

    AST_B_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_en && fwd_pend) |=> b_irq); // R8
    AST_A_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !ret_en |=> !a_irq); // R8
    AST_A_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
        (a_wr[SLOT_RET_EN] && a_wdata[MASK_SHIFT]) |=> (ret_en == $past(a_wdata[0]))); // R11

endmodule

// File: tb/duplex_mailbox_tb.sv
module duplex_mailbox_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  a_addr = '0, b_addr = '0;
    logic        a_we = 1'b0, b_we = 1'b0;
    logic [31:0] a_wdata = '0, b_wdata = '0;
    logic [31:0] a_rdata, b_rdata;
    logic        a_irq, b_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    duplex_mailbox dut_i (
        .clk(clk), .rst_n(rst_n),
        .a_addr(a_addr), .a_we(a_we), .a_wdata(a_wdata), .a_rdata(a_rdata), .a_irq(a_irq),
        .b_addr(b_addr), .b_we(b_we), .b_wdata(b_wdata), .b_rdata(b_rdata), .b_irq(b_irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // called at a negedge; write lands on the following posedge
    task automatic wr_a(input logic [5:0] ad, input logic [31:0] d);
        a_addr = ad; a_wdata = d; a_we = 1'b1;
        @(negedge clk);
        a_we = 1'b0;
    endtask

    task automatic wr_b(input logic [5:0] ad, input logic [31:0] d);
        b_addr = ad; b_wdata = d; b_we = 1'b1;
        @(negedge clk);
        b_we = 1'b0;
    endtask

    task automatic wr_both(input logic [5:0] aa, input logic [31:0] ad,
                           input logic [5:0] ba, input logic [31:0] bd);
        a_addr = aa; a_wdata = ad; a_we = 1'b1;
        b_addr = ba; b_wdata = bd; b_we = 1'b1;
        @(negedge clk);
        a_we = 1'b0; b_we = 1'b0;
    endtask

    task automatic rd_a(input logic [5:0] ad, output logic [31:0] d);
        a_addr = ad; #1; d = a_rdata;
    endtask

    task automatic rd_b(input logic [5:0] ad, output logic [31:0] d);
        b_addr = ad; #1; d = b_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int i = 0; i < 8; i++) begin
            rd_a(6'(i*4), v); check("R1 side A read", v, 32'h0);
            rd_b(6'(i*4), v); check("R1 side B read", v, 32'h0);
        end
        check("R1 a_irq", {31'b0, a_irq}, 32'h0);
        check("R1 b_irq", {31'b0, b_irq}, 32'h0);
    endtask

    task automatic t_mask();
        logic [31:0] v;
        wr_a(6'h00, 32'h0000_0001); rd_a(6'h00, v); check("R2 unmasked set ignored", v, 32'h0);
        wr_a(6'h00, 32'h0001_0001); rd_a(6'h00, v); check("R2 masked set", v, 32'h1);
        wr_a(6'h00, 32'h0000_0000); rd_a(6'h00, v); check("R2 unmasked clear ignored", v, 32'h1);
        wr_a(6'h00, 32'h0001_0000); rd_a(6'h00, v); check("R2 masked clear", v, 32'h0);
        wr_a(6'h00, 32'h0001_0001);
    endtask

    task automatic t_cmd_trigger();
        logic [31:0] v;
        wr_a(6'h08, 32'hCAFE_0001);
        rd_b(6'h04, v); check("R3 status after cmd", v, 32'h1);
        rd_a(6'h04, v); check("R3 status seen by sender", v, 32'h1);
        check("R8 b_irq not yet", {31'b0, b_irq}, 32'h0);
        @(negedge clk);
        check("R8 b_irq one cycle later", {31'b0, b_irq}, 32'h1);
        rd_b(6'h08, v); check("R3 command word", v, 32'hCAFE_0001);
        wr_a(6'h04, 32'h1); rd_b(6'h04, v); check("R6 sender clear ignored", v, 32'h1);
        wr_b(6'h04, 32'h0); rd_b(6'h04, v); check("R6 zero write ignored", v, 32'h1);
        wr_b(6'h04, 32'h1); rd_b(6'h04, v); check("R6 receiver clear", v, 32'h0);
        check("R8 b_irq still high", {31'b0, b_irq}, 32'h1);
        @(negedge clk);
        check("R8 b_irq falls", {31'b0, b_irq}, 32'h0);
    endtask

    task automatic t_data_trigger();
        logic [31:0] v;
        wr_a(6'h00, 32'h0100_0100); rd_a(6'h00, v); check("R4 trigger select set", v, 32'h101);
        wr_a(6'h08, 32'h0000_00AA); rd_b(6'h04, v); check("R4 cmd alone quiet", v, 32'h0);
        @(negedge clk);
        check("R4 no irq after cmd", {31'b0, b_irq}, 32'h0);
        wr_a(6'h0C, 32'h0000_1234); rd_b(6'h04, v); check("R4 data write fires", v, 32'h1);
        rd_b(6'h08, v); check("R4 cmd word", v, 32'h0000_00AA);
        rd_b(6'h0C, v); check("R4 data word", v, 32'h0000_1234);
        wr_b(6'h04, 32'h1); rd_b(6'h04, v); check("R6 clear data mode", v, 32'h0);
        wr_a(6'h00, 32'h0100_0000);
    endtask

    task automatic t_return();
        logic [31:0] v;
        wr_b(6'h10, 32'h0101_0101); rd_b(6'h10, v); check("R5 return bit8 absent", v, 32'h1);
        wr_b(6'h1C, 32'h5555_0000); rd_a(6'h14, v); check("R5 data alone quiet", v, 32'h0);
        wr_b(6'h18, 32'h0000_BEEF); rd_a(6'h14, v); check("R5 cmd fires return", v, 32'h1);
        @(negedge clk);
        check("R8 a_irq raised", {31'b0, a_irq}, 32'h1);
        rd_a(6'h1C, v); check("R5 data word", v, 32'h5555_0000);
        wr_a(6'h14, 32'h1); rd_a(6'h14, v); check("R6 side A clears", v, 32'h0);
    endtask

    task automatic t_irq_off();
        logic [31:0] v;
        wr_b(6'h10, 32'h0001_0000);
        wr_b(6'h18, 32'h0000_0002); rd_a(6'h14, v); check("R8 pending without enable", v, 32'h1);
        @(negedge clk); @(negedge clk);
        check("R8 a_irq gated", {31'b0, a_irq}, 32'h0);
    endtask

    task automatic t_collision();
        logic [31:0] v;
        wr_both(6'h14, 32'h1, 6'h18, 32'h0000_0003);
        rd_a(6'h14, v); check("R7 fire beats clear", v, 32'h1);
        rd_a(6'h18, v); check("R7 new command stored", v, 32'h3);
        wr_a(6'h14, 32'h1); rd_a(6'h14, v); check("R7 later clear", v, 32'h0);
        wr_both(6'h10, 32'h0001_0001, 6'h10, 32'h0001_0000);
        rd_b(6'h10, v); check("R11 side A wins", v, 32'h1);
    endtask

    task automatic t_ownership();
        logic [31:0] v;
        wr_b(6'h08, 32'hDEAD_DEAD); rd_a(6'h08, v); check("R9 fwd cmd kept", v, 32'h0000_00AA);
        wr_b(6'h0C, 32'hDEAD_DEAD); rd_a(6'h0C, v); check("R9 fwd data kept", v, 32'h0000_1234);
        wr_a(6'h18, 32'hDEAD_DEAD); rd_b(6'h18, v); check("R9 ret cmd kept", v, 32'h3);
        wr_a(6'h1C, 32'hDEAD_DEAD); rd_b(6'h1C, v); check("R9 ret data kept", v, 32'h5555_0000);
        rd_a(6'h04, v); check("R9 no stray fire", v, 32'h0);
    endtask

    task automatic t_reserved();
        logic [31:0] v;
        for (int i = 8; i < 16; i++) begin
            wr_a(6'(i*4), 32'hFFFF_FFFF);
            rd_a(6'(i*4), v); check("R10 reserved reads zero", v, 32'h0);
        end
        rd_b(6'h00, v); check("R10 fwd enable untouched", v, 32'h1);
        rd_b(6'h04, v); check("R10 fwd status untouched", v, 32'h0);
        rd_b(6'h08, v); check("R10 fwd cmd untouched", v, 32'h0000_00AA);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mask();
        t_cmd_trigger();
        t_data_trigger();
        t_return();
        t_irq_off();
        t_collision();
        t_ownership();
        t_reserved();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule